// File: doc/BRIEF.md
# Local Countdown Timer

This block is a 32-bit countdown timer that sits next to a processor's local interrupt logic. Software loads a start value, picks a prescale ratio and programs a control entry that holds an 8-bit vector, a mask bit and a repeat bit. Each write of the start value restarts the countdown from that value. The count steps down once per prescaled tick.

When the count expires, the block raises a single-cycle request that carries the programmed vector, unless the mask bit is set. In one-shot mode the count then stays at zero. In repeat mode it reloads and runs again, with a period of the start value plus one ticks. The live count is always visible on an output so that a register reader can return it.

The counting core is a four-state machine:

- **ST_IDLE**: not armed, because of reset or a start value of zero.
- **ST_COUNT**: stepping down from a nonzero value.
- **ST_ZERO**: the count has reached zero and the machine waits one more tick.
- **ST_HELD**: a finished one-shot.

Its transitions are:

- **LOAD**: any start-value write. It goes to ST_IDLE for a zero value and to ST_COUNT otherwise.
- **STEP**: a tick in ST_COUNT.
- **REACH**: a tick in ST_COUNT when the count is 1. It goes to ST_ZERO.
- **EXPIRE_RELOAD**: a tick in ST_ZERO in repeat mode. It goes back to ST_COUNT with the start value.
- **EXPIRE_STOP**: a tick in ST_ZERO in one-shot mode. It goes to ST_HELD.

Top module: `local_countdown_timer`

## Requirements
- R1: After reset the control entry is masked (mask set, repeat clear, vector 0), the count reads 0, and no request is raised even when a count is later started without writing the entry.
- R2: The divide write keeps only bits 3, 1 and 0. A code v is formed with bit 3 as v[2] and bits 1:0 as v[1:0]. The prescale shift is (v+1) mod 8, so the tick period is 2^shift clock cycles; code 7 gives one tick per cycle and code 0 gives one tick every 2 cycles.
- R3: A start-value write of N sets the count to N on the next cycle and restarts the prescaler phase, so the first decrement comes exactly 2^shift cycles after the write. Without a tick or a write, the count does not change.
- R4: In one-shot mode (entry bit 17 clear), the count after t ticks is N−t, held at 0 once t ≥ N. Exactly one expiry occurs, on tick N+1.
- R5: In repeat mode (entry bit 17 set), the count after t ticks is N − (t mod (N+1)). An expiry occurs on every tick where t is a nonzero multiple of N+1.
- R6: A start value of 0 never produces an expiry in either mode, and the count stays 0.
- R7: When the mask (entry bit 16) is set at the expiry tick, no request is raised, and the count still follows R4/R5.
- R8: The request is high for exactly one cycle, in the cycle after the expiry tick. The vector output then equals entry bits 7:0, and it is 0 in every other cycle.
- R9: A divide write does not alter the count. The old period is used up to the next tick, and the new period applies from that tick onward.
- R10: A finished one-shot stays at 0 with no request, even if the entry is later rewritten to repeat mode and unmasked, until the next start-value write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_wr_i | input | 1 | Start-value write strobe |
| init_val_i | input | 32 | Start value |
| div_wr_i | input | 1 | Divide configuration write strobe |
| div_val_i | input | 32 | Divide configuration (bits 3, 1, 0 used) |
| entry_wr_i | input | 1 | Control entry write strobe |
| entry_val_i | input | 32 | Control entry: bit 17 repeat, bit 16 mask, bits 7:0 vector |
| count_o | output | 32 | Live count |
| irq_pulse_o | output | 1 | Expiry request, one cycle |
| irq_vector_o | output | 8 | Vector accompanying the request, 0 otherwise |

## Verification
The assertions check the following on every cycle:

- the spacing between ticks once a shift has taken effect;
- that the count holds still when there is no tick and no write;
- the single decrement per tick and the reload value in repeat mode;
- the zero count in ST_ZERO and ST_HELD;
- the blocking effect of the mask;
- the single-cycle width of the request and the quiet vector outside it.

Only the bench scenarios can show the following:

- the absolute cycle at which each expiry appears for a given start value and divide code;
- the scattered divide encoding, including ignored bits;
- the hand-over of a mid-run divide change;
- the zero start value;
- the reset-masked entry;
- the one-shot that stays held after the entry is rewritten.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int VEC_W        = 8;
    localparam int BIT_PERIODIC = 17;
    localparam int BIT_MASK     = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_ZERO,
        ST_HELD
    } lct_state_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } lct_entry_t;

    // Scattered divide code: bit 3 becomes the top bit of the code.
    function automatic logic [2:0] div_shift(input logic b3, input logic [1:0] lo);
        logic [2:0] code;
        code = {b3, lo};
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic               cfg_wr_i,
    input  logic [SHIFT_W-1:0] cfg_shift_i,
    output logic               tick_o
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0]   pre_q;
    logic [PRE_W-1:0]   mask;
    logic [SHIFT_W-1:0] shift_pend_q, shift_act_q, pend_next;
    logic               boundary;

    assign mask      = PRE_W'((PRE_W+1)'(1) << shift_act_q) - PRE_W'(1);
    assign boundary  = (pre_q == mask);
    assign pend_next = cfg_wr_i ? cfg_shift_i : shift_pend_q;
    assign tick_o    = boundary && !restart_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q        <= '0;
            shift_pend_q <= SHIFT_W'(1);
            shift_act_q  <= SHIFT_W'(1);
        end else begin
            shift_pend_q <= pend_next;
            if (restart_i || boundary) begin
                pre_q       <= '0;
                shift_act_q <= pend_next;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (shift_act_q == '0 || !tick_o)); // R2

endmodule

// File: rtl/lct_count_fsm.sv
module lct_count_fsm
    import lct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             periodic_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    lct_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] reload_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (load_i) begin
            count_d = load_val_i;
            state_d = (load_val_i == '0) ? ST_IDLE : ST_COUNT;
        end else if (tick_i) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_COUNT: begin
                    count_d = count_q - CNT_W'(1);
                    if (count_q == CNT_W'(1)) state_d = ST_ZERO;
                end
                ST_ZERO: begin
                    if (periodic_i) begin
                        count_d = reload_q;
                        state_d = ST_COUNT;
                    end else begin
                        state_d = ST_HELD;
                    end
                end
                ST_HELD: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        expire_o = 1'b0;
        unique case (state_q)
            ST_ZERO:  expire_o = tick_i && !load_i;
            ST_IDLE,
            ST_COUNT,
            ST_HELD:  expire_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            count_q <= count_d;
            if (load_i) reload_q <= load_val_i;
        end
    end

    assign count_o = count_q;

    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD) |-> (count_q == '0)); // R4
    AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ZERO) |-> (count_q == '0)); // R5
    AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (count_q != '0)); // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && state_q == ST_COUNT) |=> (count_q == $past(count_q) - CNT_W'(1))); // R4
    AST_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_q)); // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && periodic_i) |=> (count_q == $past(reload_q))); // R5

endmodule

// File: rtl/lct_irq_out.sv
module lct_irq_out
    import lct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire_i,
    input  logic             masked_i,
    input  logic [VEC_W-1:0] vector_i,
    output logic             pulse_o,
    output logic [VEC_W-1:0] vector_o
);
    logic fire;
    assign fire = expire_i && !masked_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o  <= 1'b0;
            vector_o <= '0;
        end else begin
            pulse_o  <= fire;
            vector_o <= fire ? vector_i : '0;
        end
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && masked_i) |=> !pulse_o); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R8
    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_o |-> (vector_o == '0)); // R8

endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer
    import lct_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SHIFT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_wr_i,
    input  logic [31:0]      init_val_i,
    input  logic             div_wr_i,
    input  logic [31:0]      div_val_i,
    input  logic             entry_wr_i,
    input  logic [31:0]      entry_val_i,
    output logic [31:0]      count_o,
    output logic             irq_pulse_o,
    output logic [7:0]       irq_vector_o
);
    lct_entry_t       entry_q;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] count;
    logic             unused_bits;

    assign unused_bits = ^{div_val_i[31:4], div_val_i[2],
                           entry_val_i[31:BIT_PERIODIC+1], entry_val_i[BIT_MASK-1:VEC_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
        end else if (entry_wr_i) begin
            entry_q.periodic <= entry_val_i[BIT_PERIODIC];
            entry_q.masked   <= entry_val_i[BIT_MASK];
            entry_q.vector   <= entry_val_i[VEC_W-1:0];
        end
    end

    lct_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (init_wr_i),
        .cfg_wr_i   (div_wr_i),
        .cfg_shift_i(SHIFT_W'(div_shift(div_val_i[3], div_val_i[1:0]))),
        .tick_o     (tick)
    );

    lct_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (init_wr_i),
        .load_val_i(CNT_W'(init_val_i)),
        .tick_i    (tick),
        .periodic_i(entry_q.periodic),
        .count_o   (count),
        .expire_o  (expire)
    );

    lct_irq_out u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire_i(expire),
        .masked_i(entry_q.masked),
        .vector_i(entry_q.vector),
        .pulse_o (irq_pulse_o),
        .vector_o(irq_vector_o)
    );

    assign count_o = 32'(count);

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr_i && !init_wr_i && !tick) |=> $stable(count_o)); // R9

endmodule

// File: tb/tb_local_countdown_timer.sv
`timescale 1ns/1ps
module tb_local_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_wr_i = 1'b0, div_wr_i = 1'b0, entry_wr_i = 1'b0;
    logic [31:0] init_val_i = '0, div_val_i = '0, entry_val_i = '0;
    logic [31:0] count_o;
    logic        irq_pulse_o;
    logic [7:0]  irq_vector_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    local_countdown_timer dut (
        .clk(clk), .rst_n(rst_n),
        .init_wr_i(init_wr_i), .init_val_i(init_val_i),
        .div_wr_i(div_wr_i), .div_val_i(div_val_i),
        .entry_wr_i(entry_wr_i), .entry_val_i(entry_val_i),
        .count_o(count_o), .irq_pulse_o(irq_pulse_o), .irq_vector_o(irq_vector_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_period(input logic [31:0] cfg);
        logic [2:0] code;
        logic [2:0] sh;
        code = {cfg[3], cfg[1:0]};
        sh   = code + 3'd1;
        return 1 << sh;
    endfunction

    function automatic longint exp_count(input longint n, input bit per, input longint t);
        if (per) return (n == 0) ? 0 : n - (t % (n + 1));
        return (t >= n) ? 0 : n - t;
    endfunction

    function automatic bit exp_pulse(input longint n, input bit per, input bit msk,
                                     input longint k, input longint p);
        longint t;
        if (n == 0 || k == 0 || (k % p) != 0) return 1'b0;
        t = k / p;
        if ((t % (n + 1)) != 0) return 1'b0;
        if (!per && t != n + 1) return 1'b0;
        return !msk;
    endfunction

    task automatic wr_div(input logic [31:0] v);
        div_wr_i = 1'b1; div_val_i = v;
        @(negedge clk);
        div_wr_i = 1'b0;
    endtask

    task automatic wr_entry(input logic [31:0] v);
        entry_wr_i = 1'b1; entry_val_i = v;
        @(negedge clk);
        entry_wr_i = 1'b0;
    endtask

    task automatic start(input logic [31:0] n);
        init_wr_i = 1'b1; init_val_i = n;
        @(negedge clk);
        init_wr_i = 1'b0;
    endtask

    // Run from a start write for 'cycles' samples and compare every cycle.
    task automatic follow(input string req, input longint n, input bit per, input bit msk,
                          input logic [7:0] vec, input longint p, input int cycles);
        for (int k = 0; k <= cycles; k++) begin
            bit ep;
            if (k > 0) @(negedge clk);
            chk(req, "count", count_o, exp_count(n, per, k / p));
            ep = exp_pulse(n, per, msk, k, p);
            chk(req, "pulse", irq_pulse_o, ep);
            chk("R8", "vector", irq_vector_o, ep ? vec : 8'h00);
        end
    endtask

    task automatic run_case(input string req, input logic [31:0] n, input logic [31:0] cfg,
                            input bit per, input bit msk, input logic [7:0] vec,
                            input logic [31:0] noise, input int cycles);
        logic [31:0] ent;
        ent = (noise & 32'hFFFC_FF00) | (32'(per) << 17) | (32'(msk) << 16) | 32'(vec);
        wr_div(cfg);
        wr_entry(ent);
        start(n);
        follow(req, n, per, msk, vec, exp_period(cfg), cycles);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, then a count with the reset entry stays silent
        chk("R1", "count", count_o, 0);
        chk("R1", "pulse", irq_pulse_o, 0);
        chk("R1", "vector", irq_vector_o, 0);
        start(32'd2);
        follow("R1", 2, 1'b0, 1'b1, 8'h00, 2, 10);

        // R4 one-shot, divide by 1
        run_case("R4", 5, 32'hB, 1'b0, 1'b0, 8'h41, 0, 14);
        // R5 repeat, divide by 2
        run_case("R5", 3, 32'h0, 1'b1, 1'b0, 8'h7E, 0, 30);
        // R6 zero start in both modes
        run_case("R6", 0, 32'hB, 1'b1, 1'b0, 8'h11, 0, 20);
        run_case("R6", 0, 32'hB, 1'b0, 1'b0, 8'h12, 0, 20);
        // R7 masked repeat
        run_case("R7", 2, 32'hB, 1'b1, 1'b1, 8'h33, 0, 20);
        // R2 scattered encoding and ignored bits
        run_case("R2", 1, 32'h8, 1'b1, 1'b0, 8'h21, 0, 200);
        run_case("R2", 2, 32'h3, 1'b1, 1'b0, 8'h22, 0, 150);
        run_case("R2", 1, 32'hA, 1'b0, 1'b0, 8'h23, 0, 300);
        run_case("R2", 3, 32'hFFFF_FFF4, 1'b0, 1'b0, 8'h24, 32'hFFFF_FFFF, 20);
        // R3 restart in the middle of a run
        run_case("R3", 10, 32'h1, 1'b0, 1'b0, 8'h31, 0, 9);
        start(32'd3);
        follow("R3", 3, 1'b0, 1'b0, 8'h31, 4, 25);

        // R9 divide change mid-run
        wr_div(32'h0);
        wr_entry(32'h0001_0000);
        start(32'd50);
        for (int k = 1; k <= 4; k++) @(negedge clk);
        chk("R9", "count before", count_o, 48);
        div_wr_i = 1'b1; div_val_i = 32'h2;
        @(negedge clk);
        div_wr_i = 1'b0;
        chk("R9", "count after write", count_o, 48);
        for (int k = 6; k <= 22; k++) begin
            @(negedge clk);
            if (k == 6)  chk("R9", "old-rate tick", count_o, 47);
            if (k == 13) chk("R9", "new gap", count_o, 47);
            if (k == 14) chk("R9", "new-rate tick", count_o, 46);
            if (k == 22) chk("R9", "second new tick", count_o, 45);
        end

        // R10 finished one-shot stays held
        run_case("R10", 2, 32'hB, 1'b0, 1'b0, 8'h5A, 0, 8);
        wr_entry(32'h0002_005B);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R10", "held count", count_o, 0);
            chk("R10", "held pulse", irq_pulse_o, 0);
        end

        // Constrained random mix
        for (int i = 0; i < 12; i++) begin
            logic [31:0] n, cfg, noise;
            bit per, msk;
            logic [7:0] vec;
            int cyc;
            n     = $urandom % 16;
            cfg   = $urandom;
            per   = 1'($urandom);
            msk   = ($urandom % 4) == 0;
            vec   = 8'($urandom);
            noise = $urandom;
            cyc   = exp_period(cfg) * (2 * (int'(n) + 1) + 1) + 3;
            if (cyc > 4500) cyc = 4500;
            run_case(per ? "R5" : "R4", n, cfg, per, msk, vec, noise, cyc);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule